// File: doc/BRIEF.md
# Cache-Line Byte-Mask Merging Unit

This block sits between a group of load/store units and a level-one data cache whose lines are 16 bytes wide. Each unit presents one access: a byte address, an access size and a load/store flag. The block converts every access into one or two line-sized requests. Each line-sized request is a line address and a byte-enable mask with one bit per byte column of the line. An access that runs past the end of its line produces a second request for the following line.

On every clock the block chooses one target line. It gathers every compatible pending request aimed at that line into a single merged line request, so that several units are served by one cache access. Along with the merged request it returns a grant vector, and each granted unit receives its own byte mask so that it can pick out its byte lanes. A done pulse tells a unit that all of its pieces have been granted.

Moving data, the cache array, the tags and the bus signalling are handled elsewhere.

Top module: `line_merge_unit`

## Requirements
- R1: The size code selects the access width: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes and 11 is 8 bytes. The low four address bits give the starting byte offset. Mask bit i enables byte column i of the line, and bits offset through offset+width-1 are set.
- R2: An access that crosses byte 15 is split into two pieces. The first piece goes to line L and covers bytes offset..15. The second piece goes to line L+1 and covers bytes 0 upward. The first piece is granted in an earlier cycle than the second.
- R3: When the line address is all ones, the following line wraps to line address zero.
- R4: Every compatible pending piece aimed at the target line is granted in the same cycle. `line_mask` is the OR of their masks, and each granted unit's `grant_mask` slice holds its own mask.
- R5: Loads and stores are never merged into one line request. `line_store` is 1 for a store request and 0 for a load request.
- R6: Stores whose masks do not overlap are merged. A store that overlaps a store already granted from a lower-indexed unit waits for a later cycle.
- R7: The target line is the line of the lowest-indexed unit that has a pending piece.
- R8: A unit's `done` bit pulses only in the cycle in which its last piece is granted.
- R9: A request from a unit that still has pieces pending is ignored.
- R10: After reset, `line_valid`, `grant` and `done` are zero.
- R11: A request sampled at a clock edge produces its first grant at the outputs after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_UNITS | Per-unit request strobe |
| req_addr | input | N_UNITS*(LINE_ADDR_W+4) | Per-unit byte address, unit i in slice i |
| req_size | input | 2*N_UNITS | Per-unit size code |
| req_store | input | N_UNITS | Per-unit store flag (1 = store) |
| line_valid | output | 1 | A merged line request is present |
| line_addr | output | LINE_ADDR_W | Line address of the merged request |
| line_mask | output | 16 | Merged byte-enable mask |
| line_store | output | 1 | Merged request is a store |
| grant | output | N_UNITS | Units served by this line request |
| grant_mask | output | 16*N_UNITS | Each granted unit's own byte mask |
| done | output | N_UNITS | Last piece of the unit's access granted |

## Verification
The hardest case to reach from the ports is a cycle in which several units hold pieces for the same line, but only some of them may join the merge. One reason is that loads and stores are mixed. Another is that a store overlaps a store that has already been accepted. The stimulus reaches this case by presenting three stores in the same cycle, with the middle one overlapping the first and the third disjoint from both. It also presents a store and a load to the same line together. It then checks that the grant splits across two cycles with the expected masks. A split access is also re-requested while its second piece is still pending, which shows that the late request leaves no trace at the outputs.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic [1:0] {
    SZ_1B = 2'b00,
    SZ_2B = 2'b01,
    SZ_4B = 2'b10,
    SZ_8B = 2'b11
  } size_code_e;

  function automatic int unsigned size_to_bytes(input logic [1:0] code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/lm_mask_gen.sv
module lm_mask_gen #(
  parameter int LINE_BYTES = 16,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input  logic [OFF_W-1:0]      offset,
  input  logic [1:0]            size,
  output logic [LINE_BYTES-1:0] lo_mask,
  output logic [LINE_BYTES-1:0] hi_mask
);
  logic [2*LINE_BYTES-1:0] base;
  logic [2*LINE_BYTES-1:0] wide;
  int unsigned             nbytes;

  always_comb begin
    nbytes = lm_pkg::size_to_bytes(size);
    for (int b = 0; b < 2*LINE_BYTES; b++) begin
      base[b] = (b < int'(nbytes));
    end
    wide    = base << offset;
    lo_mask = wide[LINE_BYTES-1:0];
    hi_mask = wide[2*LINE_BYTES-1:LINE_BYTES];
  end
endmodule

// File: rtl/lm_slot.sv
module lm_slot #(
  parameter int LINE_ADDR_W = 44,
  parameter int LINE_BYTES  = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int ADDR_W = LINE_ADDR_W + OFF_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic [1:0]             in_size,
  input  logic                   in_store,
  input  logic                   take,
  output logic                   cur_valid,
  output logic [LINE_ADDR_W-1:0] cur_line,
  output logic [LINE_BYTES-1:0]  cur_mask,
  output logic                   cur_store,
  output logic                   cur_last
);
  logic                   pend_lo, pend_hi;
  logic [LINE_ADDR_W-1:0] line_q;
  logic [LINE_BYTES-1:0]  lo_q, hi_q;
  logic                   store_q;
  logic [LINE_BYTES-1:0]  lo_new, hi_new;
  logic                   busy;

  lm_mask_gen #(.LINE_BYTES(LINE_BYTES)) mask_i (
    .offset (in_addr[OFF_W-1:0]),
    .size   (in_size),
    .lo_mask(lo_new),
    .hi_mask(hi_new)
  );

  assign busy = pend_lo | pend_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_lo <= 1'b0;
      pend_hi <= 1'b0;
      line_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      store_q <= 1'b0;
    end else if (!busy) begin
      if (in_valid) begin
        pend_lo <= 1'b1;
        pend_hi <= |hi_new;
        line_q  <= in_addr[ADDR_W-1:OFF_W];
        lo_q    <= lo_new;
        hi_q    <= hi_new;
        store_q <= in_store;
      end
    end else if (take) begin
      if (pend_lo) pend_lo <= 1'b0;
      else         pend_hi <= 1'b0;
    end
  end

  always_comb begin
    cur_valid = busy;
    cur_store = store_q;
    cur_line  = pend_lo ? line_q : LINE_ADDR_W'(line_q + 1'b1);
    cur_mask  = pend_lo ? lo_q : hi_q;
    cur_last  = pend_lo ? !pend_hi : 1'b1;
  end
endmodule

// File: rtl/lm_select.sv
module lm_select #(
  parameter int N_UNITS     = 8,
  parameter int LINE_ADDR_W = 44,
  parameter int LINE_BYTES  = 16
) (
  input  logic [N_UNITS-1:0]                  cur_valid,
  input  logic [N_UNITS-1:0][LINE_ADDR_W-1:0] cur_line,
  input  logic [N_UNITS-1:0][LINE_BYTES-1:0]  cur_mask,
  input  logic [N_UNITS-1:0]                  cur_store,
  output logic [N_UNITS-1:0]                  sel_grant,
  output logic                                sel_valid,
  output logic [LINE_ADDR_W-1:0]              sel_line,
  output logic [LINE_BYTES-1:0]               sel_mask,
  output logic                                sel_store
);
  logic                   found;
  logic [LINE_ADDR_W-1:0] tgt_line;
  logic                   tgt_store;
  logic [LINE_BYTES-1:0]  acc;
  logic                   ok;

  always_comb begin
    found     = 1'b0;
    tgt_line  = '0;
    tgt_store = 1'b0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (!found && cur_valid[i]) begin
        found     = 1'b1;
        tgt_line  = cur_line[i];
        tgt_store = cur_store[i];
      end
    end
    acc       = '0;
    sel_grant = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      ok = cur_valid[i] && (cur_line[i] == tgt_line) && (cur_store[i] == tgt_store);
      if (tgt_store && ((acc & cur_mask[i]) != '0)) ok = 1'b0;
      if (ok) begin
        sel_grant[i] = 1'b1;
        acc          = acc | cur_mask[i];
      end
    end
    sel_valid = found;
    sel_line  = tgt_line;
    sel_mask  = acc;
    sel_store = tgt_store;
  end
endmodule

// File: rtl/line_merge_unit.sv
module line_merge_unit #(
  parameter int N_UNITS     = 8,
  parameter int LINE_ADDR_W = 44,
  parameter int LINE_BYTES  = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int ADDR_W = LINE_ADDR_W + OFF_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N_UNITS-1:0]              req_valid,
  input  logic [N_UNITS*ADDR_W-1:0]       req_addr,
  input  logic [2*N_UNITS-1:0]            req_size,
  input  logic [N_UNITS-1:0]              req_store,
  output logic                            line_valid,
  output logic [LINE_ADDR_W-1:0]          line_addr,
  output logic [LINE_BYTES-1:0]           line_mask,
  output logic                            line_store,
  output logic [N_UNITS-1:0]              grant,
  output logic [N_UNITS*LINE_BYTES-1:0]   grant_mask,
  output logic [N_UNITS-1:0]              done
);
  logic [N_UNITS-1:0]                  cur_valid, cur_store, cur_last, sel_grant;
  logic [N_UNITS-1:0][LINE_ADDR_W-1:0] cur_line;
  logic [N_UNITS-1:0][LINE_BYTES-1:0]  cur_mask;
  logic                                sel_valid, sel_store;
  logic [LINE_ADDR_W-1:0]              sel_line;
  logic [LINE_BYTES-1:0]               sel_mask;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_slot
    lm_slot #(.LINE_ADDR_W(LINE_ADDR_W), .LINE_BYTES(LINE_BYTES)) slot_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (req_valid[u]),
      .in_addr  (req_addr[u*ADDR_W +: ADDR_W]),
      .in_size  (req_size[2*u +: 2]),
      .in_store (req_store[u]),
      .take     (sel_grant[u]),
      .cur_valid(cur_valid[u]),
      .cur_line (cur_line[u]),
      .cur_mask (cur_mask[u]),
      .cur_store(cur_store[u]),
      .cur_last (cur_last[u])
    );
  end

  lm_select #(.N_UNITS(N_UNITS), .LINE_ADDR_W(LINE_ADDR_W), .LINE_BYTES(LINE_BYTES)) sel_i (
    .cur_valid(cur_valid),
    .cur_line (cur_line),
    .cur_mask (cur_mask),
    .cur_store(cur_store),
    .sel_grant(sel_grant),
    .sel_valid(sel_valid),
    .sel_line (sel_line),
    .sel_mask (sel_mask),
    .sel_store(sel_store)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_valid <= 1'b0;
      line_addr  <= '0;
      line_mask  <= '0;
      line_store <= 1'b0;
      grant      <= '0;
      grant_mask <= '0;
      done       <= '0;
    end else begin
      line_valid <= sel_valid;
      line_addr  <= sel_line;
      line_mask  <= sel_mask;
      line_store <= sel_store;
      grant      <= sel_grant;
      done       <= sel_grant & cur_last;
      for (int u = 0; u < N_UNITS; u++) begin
        grant_mask[u*LINE_BYTES +: LINE_BYTES] <= sel_grant[u] ? cur_mask[u] : '0;
      end
    end
  end
endmodule

// File: rtl/lm_checker.sv
module lm_checker #(
  parameter int N_UNITS    = 8,
  parameter int LINE_BYTES = 16
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          line_valid,
  input logic                          line_store,
  input logic [LINE_BYTES-1:0]         line_mask,
  input logic [N_UNITS-1:0]            grant,
  input logic [N_UNITS*LINE_BYTES-1:0] grant_mask,
  input logic [N_UNITS-1:0]            done
);
  logic [LINE_BYTES-1:0] gm_or;
  int unsigned           gm_bits;

  always_comb begin
    gm_or   = '0;
    gm_bits = 0;
    for (int u = 0; u < N_UNITS; u++) begin
      gm_or   = gm_or | grant_mask[u*LINE_BYTES +: LINE_BYTES];
      gm_bits = gm_bits + $countones(grant_mask[u*LINE_BYTES +: LINE_BYTES]);
    end
  end

  AST_DONE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (done & ~grant) == '0); // R8
  AST_MASK_IS_UNION: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> (gm_or == line_mask)); // R4
  AST_STORE_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (line_valid && line_store) |-> (gm_bits == $countones(line_mask))); // R6
  AST_GRANT_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> line_valid); // R7
  AST_LINE_HAS_BYTES: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> (line_mask != '0 && grant != '0)); // R1
endmodule

bind line_merge_unit lm_checker #(.N_UNITS(N_UNITS), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .line_valid(line_valid),
  .line_store(line_store),
  .line_mask (line_mask),
  .grant     (grant),
  .grant_mask(grant_mask),
  .done      (done)
);

// File: tb/line_merge_unit_tb_top.sv
module line_merge_unit_tb_top;
  localparam int NU = 8;
  localparam int LA = 44;
  localparam int AW = 48;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NU-1:0]     req_valid = '0;
  logic [NU*AW-1:0]  req_addr = '0;
  logic [2*NU-1:0]   req_size = '0;
  logic [NU-1:0]     req_store = '0;
  logic              line_valid, line_store;
  logic [LA-1:0]     line_addr;
  logic [15:0]       line_mask;
  logic [NU-1:0]     grant, done;
  logic [NU*16-1:0]  grant_mask;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  line_merge_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_store(req_store), .line_valid(line_valid),
    .line_addr(line_addr), .line_mask(line_mask), .line_store(line_store),
    .grant(grant), .grant_mask(grant_mask), .done(done)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input int u, input logic [47:0] a, input logic [1:0] s, input logic st);
    req_valid[u] = 1'b1;
    req_addr[u*AW +: AW] = a;
    req_size[2*u +: 2] = s;
    req_store[u] = st;
  endtask

  task automatic clr();
    req_valid = '0;
  endtask

  task automatic expect_line(input string req, input logic [LA-1:0] la, input logic [15:0] m,
                             input logic st, input logic [7:0] g, input logic [7:0] d);
    chk(req, "line_valid", 64'(line_valid), 64'd1);
    chk(req, "line_addr", 64'(line_addr), 64'(la));
    chk(req, "line_mask", 64'(line_mask), 64'(m));
    chk(req, "line_store", 64'(line_store), 64'(st));
    chk(req, "grant", 64'(grant), 64'(g));
    chk(req, "done", 64'(done), 64'(d));
  endtask

  task automatic expect_idle(input string req);
    chk(req, "idle line_valid", 64'(line_valid), 64'd0);
    chk(req, "idle grant", 64'(grant), 64'd0);
  endtask

  task automatic t_reset();
    chk("R10", "line_valid", 64'(line_valid), 64'd0);
    chk("R10", "grant", 64'(grant), 64'd0);
    chk("R10", "done", 64'(done), 64'd0);
  endtask

  // R1 R7 R11: three units, distinct lines, served lowest index first
  task automatic t_sizes();
    put(0, 48'h0000_0000_0105, 2'b01, 1'b0);
    put(5, 48'h0000_0000_0203, 2'b10, 1'b0);
    put(7, 48'h0000_0000_030F, 2'b00, 1'b0);
    @(negedge clk); clr();
    @(negedge clk); expect_line("R1_R7_R11 unit0", 44'h10, 16'h0060, 1'b0, 8'h01, 8'h01);
    @(negedge clk); expect_line("R1_R7 unit5", 44'h20, 16'h0078, 1'b0, 8'h20, 8'h20);
    @(negedge clk); expect_line("R1_R7 unit7", 44'h30, 16'h8000, 1'b0, 8'h80, 8'h80);
    @(negedge clk); expect_idle("R7 drained");
  endtask

  // R2 R8: line-crossing access
  task automatic t_split();
    put(1, 48'h0000_0000_0ABE, 2'b11, 1'b0);
    @(negedge clk); clr();
    @(negedge clk); expect_line("R2_R8 first piece", 44'hAB, 16'hC000, 1'b0, 8'h02, 8'h00);
    @(negedge clk); expect_line("R2_R8 second piece", 44'hAC, 16'h003F, 1'b0, 8'h02, 8'h02);
    @(negedge clk); expect_idle("R2 drained");
  endtask

  // R4: loads to one line merge, own masks returned
  task automatic t_merge();
    put(0, 48'h0000_0000_0500, 2'b10, 1'b0);
    put(3, 48'h0000_0000_0502, 2'b01, 1'b0);
    put(5, 48'h0000_0000_0508, 2'b00, 1'b0);
    put(4, 48'h0000_0000_0510, 2'b11, 1'b0);
    @(negedge clk); clr();
    @(negedge clk);
    expect_line("R4 merged", 44'h50, 16'h010F, 1'b0, 8'h29, 8'h29);
    chk("R4", "unit3 own mask", 64'(grant_mask[3*16 +: 16]), 64'h000C);
    chk("R4", "unit5 own mask", 64'(grant_mask[5*16 +: 16]), 64'h0100);
    @(negedge clk); expect_line("R4 other line", 44'h51, 16'h00FF, 1'b0, 8'h10, 8'h10);
  endtask

  // R5: load and store to same line kept apart
  task automatic t_mix();
    put(0, 48'h0000_0000_0600, 2'b10, 1'b1);
    put(1, 48'h0000_0000_0604, 2'b10, 1'b0);
    @(negedge clk); clr();
    @(negedge clk); expect_line("R5 store alone", 44'h60, 16'h000F, 1'b1, 8'h01, 8'h01);
    @(negedge clk); expect_line("R5 load after", 44'h60, 16'h00F0, 1'b0, 8'h02, 8'h02);
  endtask

  // R6: overlapping store waits, disjoint store merges
  task automatic t_stores();
    put(0, 48'h0000_0000_0700, 2'b10, 1'b1);
    put(1, 48'h0000_0000_0702, 2'b01, 1'b1);
    put(2, 48'h0000_0000_0704, 2'b10, 1'b1);
    @(negedge clk); clr();
    @(negedge clk); expect_line("R6 disjoint merged", 44'h70, 16'h00FF, 1'b1, 8'h05, 8'h05);
    @(negedge clk); expect_line("R6 overlap waited", 44'h70, 16'h000C, 1'b1, 8'h02, 8'h02);
  endtask

  // R3: wrap of the following line
  task automatic t_wrap();
    put(3, 48'hFFFF_FFFF_FFFC, 2'b11, 1'b0);
    @(negedge clk); clr();
    @(negedge clk); expect_line("R3 top line", 44'hFFF_FFFF_FFFF, 16'hF000, 1'b0, 8'h08, 8'h00);
    @(negedge clk); expect_line("R3 wrapped", 44'h0, 16'h000F, 1'b0, 8'h08, 8'h08);
  endtask

  // R9: request while busy ignored
  task automatic t_busy();
    put(1, 48'h0000_0000_0ABE, 2'b11, 1'b0);
    @(negedge clk); put(1, 48'h0000_0000_0900, 2'b00, 1'b1);
    @(negedge clk); clr();
    expect_line("R9 first piece", 44'hAB, 16'hC000, 1'b0, 8'h02, 8'h00);
    @(negedge clk); expect_line("R9 second piece intact", 44'hAC, 16'h003F, 1'b0, 8'h02, 8'h02);
    @(negedge clk); expect_idle("R9 late request dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_split();
    t_merge();
    t_mix();
    t_stores();
    t_wrap();
    t_busy();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule